// File: doc/BRIEF.md
# Key-Protected Register Write Guard

This block sits on the write path of a peripheral's configuration registers. For every write it decides whether the write may reach its target. While protection is on, it suppresses writes to a chosen set of configuration offsets. It also remembers the offset of the most recent suppressed write. Protection is switched on or off only through one protection-control register, and only when the write carries a fixed 24-bit unlock key in its upper bits. A write with any other key has no effect on the protection state.

A status register reports whether a suppressed write has happened since that register was last read, and which offset the write targeted. Reading the status register clears it. A violation that arrives in the same cycle as the read is kept. Readback is combinational from the offset presented with the read strobe. The protected registers themselves belong to the host peripheral. They see only the allow signal.

Top module: `regwr_guard`

## Requirements
- R1: After reset, protection is off and both the control readback (offset 0xE4) and the status readback (offset 0xE8) are zero.
- R2: A write to offset 0xE4 whose bits 31:8 equal 0x515350 sets the protection state to bit 0 of the write data, effective from the next cycle.
- R3: A write to offset 0xE4 whose bits 31:8 differ from 0x515350 leaves the protection state unchanged.
- R4: Reading offset 0xE4 returns the protection state in bit 0 and zero in bits 31:1, so the key field always reads as zero.
- R5: While protection is on, `wr_allow` is low in the same cycle as a write to offset 0x04, 0x20, 0x30, 0x34, 0x38 or 0x40. While protection is off, `wr_allow` is high for such a write.
- R6: A write to any offset outside the protected set and other than 0xE4 is always allowed.
- R7: Each suppressed write sets the status flag (bit 0 of offset 0xE8) and loads its offset into bits 15:8 of that register from the next cycle. A later suppressed write replaces the recorded offset.
- R8: A read strobe at offset 0xE8 returns the current status in that cycle and clears the flag and the source field from the next cycle.
- R9: If a suppressed write and a status read fall in the same cycle, the read returns the old status and the new violation stays latched.
- R10: A write to offset 0xE4 is never suppressed, whatever the protection state.
- R11: `wr_allow` is low whenever `wr_en` is low.
- R12: A read at any offset other than 0xE4 and 0xE8 returns zero and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_off | input | 8 | Byte offset of the read |
| wr_allow | output | 1 | The write may reach its target register |
| rd_data | output | 32 | Readback data for the control or status register |

## Verification
A wrong protection state shows up in the next write to a protected offset. `wr_allow` takes the wrong level in that same cycle. The control readback also reports the wrong bit 0 at once. A wrong status state, such as a missed latch, a stale source offset or a clear that loses a coincident violation, appears in the first status read after the event. The bench therefore pairs each suppressed write with a read within a few cycles. In random runs it reads the status often enough that a stuck flag cannot stay hidden for long.

// File: rtl/regwr_guard_pkg.sv
package regwr_guard_pkg;

   localparam int unsigned GUARD_DATA_W  = 32;
   localparam int unsigned GUARD_OFF_W   = 8;
   localparam int unsigned GUARD_KEY_W   = 24;
   localparam logic [23:0] GUARD_KEY     = 24'h515350;
   localparam logic [7:0]  GUARD_CTL_OFF = 8'hE4;
   localparam logic [7:0]  GUARD_STS_OFF = 8'hE8;
   localparam int unsigned GUARD_N_PROT  = 6;
   localparam logic [47:0] GUARD_PROT_LIST =
      {8'h40, 8'h38, 8'h34, 8'h30, 8'h20, 8'h04};
   localparam int unsigned GUARD_SRC_LSB = 8;

   typedef struct packed {
      logic is_prot;
      logic is_ctl;
      logic is_sts;
   } off_class_t;

endpackage

// File: rtl/regwr_guard_decode.sv
module regwr_guard_decode
   import regwr_guard_pkg::*;
#(
   parameter int unsigned              OFF_W     = 8,
   parameter int unsigned              N_PROT    = 6,
   parameter logic [N_PROT*OFF_W-1:0]  PROT_LIST = '0,
   parameter logic [OFF_W-1:0]         CTL_OFF   = '0,
   parameter logic [OFF_W-1:0]         STS_OFF   = '0
) (
   input  logic [OFF_W-1:0] off,
   output off_class_t       cls
);

   logic [N_PROT-1:0] hit;

   for (genvar i = 0; i < N_PROT; i++) begin : g_match
      assign hit[i] = (off == PROT_LIST[i*OFF_W +: OFF_W]);
   end

   always_comb begin
      cls.is_prot = |hit;
      cls.is_ctl  = (off == CTL_OFF);
      cls.is_sts  = (off == STS_OFF);
   end

endmodule

// File: rtl/regwr_guard_ctl.sv
module regwr_guard_ctl #(
   parameter int unsigned       DATA_W = 32,
   parameter int unsigned       KEY_W  = 24,
   parameter logic [KEY_W-1:0]  KEY    = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] data,
   output logic              prot_on
);

   logic key_ok;

   assign key_ok = (data[DATA_W-1 -: KEY_W] == KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_on <= 1'b0;
      end else if (ctl_wr && key_ok) begin
         prot_on <= data[0];
      end
   end

endmodule

// File: rtl/regwr_guard_viol.sv
module regwr_guard_viol #(
   parameter int unsigned OFF_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             viol,
   input  logic             clr,
   input  logic [OFF_W-1:0] off,
   output logic             vflag,
   output logic [OFF_W-1:0] vsrc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vflag <= 1'b0;
         vsrc  <= '0;
      end else if (viol) begin
         vflag <= 1'b1;
         vsrc  <= off;
      end else if (clr) begin
         vflag <= 1'b0;
         vsrc  <= '0;
      end
   end

endmodule

// File: rtl/regwr_guard.sv
module regwr_guard
   import regwr_guard_pkg::*;
#(
   parameter int unsigned                 DATA_W    = GUARD_DATA_W,
   parameter int unsigned                 OFF_W     = GUARD_OFF_W,
   parameter int unsigned                 KEY_W     = GUARD_KEY_W,
   parameter logic [KEY_W-1:0]            KEY       = GUARD_KEY,
   parameter logic [OFF_W-1:0]            CTL_OFF   = GUARD_CTL_OFF,
   parameter logic [OFF_W-1:0]            STS_OFF   = GUARD_STS_OFF,
   parameter int unsigned                 N_PROT    = GUARD_N_PROT,
   parameter logic [N_PROT*OFF_W-1:0]     PROT_LIST = GUARD_PROT_LIST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFF_W-1:0]  wr_off,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [OFF_W-1:0]  rd_off,
   output logic              wr_allow,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned SRC_LSB = GUARD_SRC_LSB;
   localparam int unsigned SRC_MSB = SRC_LSB + OFF_W - 1;

   if (KEY_W + 1 > DATA_W) begin : g_bad_key
      $error("regwr_guard: key field does not fit above the enable bit");
   end
   if (SRC_MSB >= DATA_W) begin : g_bad_src
      $error("regwr_guard: source field does not fit in the data word");
   end
   if (N_PROT < 1) begin : g_bad_list
      $error("regwr_guard: protected list is empty");
   end
   if (CTL_OFF == STS_OFF) begin : g_bad_map
      $error("regwr_guard: control and status offsets collide");
   end

   off_class_t       wcls;
   off_class_t       rcls;
   logic             prot_on;
   logic             vflag;
   logic [OFF_W-1:0] vsrc;
   logic             blocked;

   regwr_guard_decode #(
      .OFF_W(OFF_W), .N_PROT(N_PROT), .PROT_LIST(PROT_LIST),
      .CTL_OFF(CTL_OFF), .STS_OFF(STS_OFF)
   ) u_wdec (
      .off(wr_off),
      .cls(wcls)
   );

   regwr_guard_decode #(
      .OFF_W(OFF_W), .N_PROT(N_PROT), .PROT_LIST(PROT_LIST),
      .CTL_OFF(CTL_OFF), .STS_OFF(STS_OFF)
   ) u_rdec (
      .off(rd_off),
      .cls(rcls)
   );

   regwr_guard_ctl #(
      .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY(KEY)
   ) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl_wr (wr_en && wcls.is_ctl),
      .data   (wr_data),
      .prot_on(prot_on)
   );

   assign blocked  = wr_en && prot_on && wcls.is_prot && !wcls.is_ctl;
   assign wr_allow = wr_en && !blocked;

   regwr_guard_viol #(
      .OFF_W(OFF_W)
   ) u_viol (
      .clk  (clk),
      .rst_n(rst_n),
      .viol (blocked),
      .clr  (rd_en && rcls.is_sts),
      .off  (wr_off),
      .vflag(vflag),
      .vsrc (vsrc)
   );

   always_comb begin
      rd_data = '0;
      if (rd_en && rcls.is_ctl) begin
         rd_data[0] = prot_on;
      end else if (rd_en && rcls.is_sts) begin
         rd_data[0]                = vflag;
         rd_data[SRC_MSB:SRC_LSB]  = vsrc;
      end
   end

endmodule

// File: rtl/regwr_guard_chk.sv
module regwr_guard_chk #(
   parameter int unsigned       DATA_W  = 32,
   parameter int unsigned       OFF_W   = 8,
   parameter int unsigned       KEY_W   = 24,
   parameter logic [KEY_W-1:0]  KEY     = '0,
   parameter logic [OFF_W-1:0]  CTL_OFF = '0,
   parameter logic [OFF_W-1:0]  STS_OFF = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [OFF_W-1:0]  wr_off,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_en,
   input logic [OFF_W-1:0]  rd_off,
   input logic              wr_allow,
   input logic              prot_on,
   input logic              vflag,
   input logic [OFF_W-1:0]  vsrc
);

   logic ctl_wr;
   logic sts_rd;
   assign ctl_wr = wr_en && (wr_off == CTL_OFF);
   assign sts_rd = rd_en && (rd_off == STS_OFF);

   p_allow_needs_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> !wr_allow);

   p_ctl_never_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |-> wr_allow);

   p_key_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wr_data[DATA_W-1 -: KEY_W] == KEY) |=> (prot_on == $past(wr_data[0])));

   p_bad_key_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wr_data[DATA_W-1 -: KEY_W] != KEY) |=> $stable(prot_on));

   p_block_latches_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_allow) |=> (vflag && vsrc == $past(wr_off)));

   p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_rd && !(wr_en && !wr_allow)) |=> (!vflag && vsrc == '0));

   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vflag && !sts_rd) |=> vflag);

   p_block_needs_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_allow) |-> prot_on);

endmodule

bind regwr_guard regwr_guard_chk #(
   .DATA_W(DATA_W), .OFF_W(OFF_W), .KEY_W(KEY_W), .KEY(KEY),
   .CTL_OFF(CTL_OFF), .STS_OFF(STS_OFF)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_off  (wr_off),
   .wr_data (wr_data),
   .rd_en   (rd_en),
   .rd_off  (rd_off),
   .wr_allow(wr_allow),
   .prot_on (prot_on),
   .vflag   (vflag),
   .vsrc    (vsrc)
);

// File: tb/regwr_guard_test.sv
module regwr_guard_test;

   localparam logic [7:0]  CTL = 8'hE4;
   localparam logic [7:0]  STS = 8'hE8;
   localparam logic [23:0] KEY = 24'h515350;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_off = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_off = '0;
   logic        wr_allow;
   logic [31:0] rd_data;

   int n_chk = 0;
   int n_bad = 0;
   bit m_en = 0;
   bit m_flag = 0;
   logic [7:0] m_src = '0;

   always #5 clk = ~clk;

   regwr_guard uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off),
      .wr_data(wr_data), .rd_en(rd_en), .rd_off(rd_off),
      .wr_allow(wr_allow), .rd_data(rd_data)
   );

   function automatic bit is_prot(input logic [7:0] o);
      return (o == 8'h04) || (o == 8'h20) || (o == 8'h30) ||
             (o == 8'h34) || (o == 8'h38) || (o == 8'h40);
   endfunction

   function automatic bit exp_allow(input bit we, input logic [7:0] o);
      return we && !(m_en && is_prot(o));
   endfunction

   function automatic logic [31:0] exp_rd(input bit re, input logic [7:0] o);
      if (!re) return '0;
      if (o == CTL) return {31'd0, m_en};
      if (o == STS) return {16'd0, m_src, 7'd0, m_flag};
      return '0;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input bit we, input logic [7:0] wo, input logic [31:0] wd,
                      input bit re, input logic [7:0] ro, input string tg);
      string ta, tr;
      bit viol;
      @(negedge clk);
      wr_en = we; wr_off = wo; wr_data = wd; rd_en = re; rd_off = ro;
      #2;
      if (tg != "") ta = tg;
      else if (!we) ta = "R11";
      else if (wo == CTL) ta = "R10";
      else if (is_prot(wo)) ta = "R5";
      else ta = "R6";
      if (tg != "") tr = tg;
      else if (re && ro == CTL) tr = "R4";
      else if (re && ro == STS) tr = "R8";
      else tr = "R12";
      check({ta, " allow"}, {31'd0, wr_allow}, {31'd0, exp_allow(we, wo)});
      check({tr, " rdata"}, rd_data, exp_rd(re, ro));
      @(posedge clk);
      viol = we && m_en && is_prot(wo);
      if (viol) begin
         m_flag = 1; m_src = wo;
      end else if (re && ro == STS) begin
         m_flag = 0; m_src = '0;
      end
      if (we && wo == CTL && wd[31:8] == KEY) m_en = wd[0];
   endtask

   task automatic idle();
      cyc(0, 8'h00, '0, 0, 8'h00, "");
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      bit          we, re;
      logic [7:0]  wo, ro;
      logic [31:0] wd;
      int unsigned r;
      void'($urandom(32'h1234_5678));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      cyc(0, 8'h00, '0, 1, CTL, "R1");
      cyc(0, 8'h00, '0, 1, STS, "R1");
      // R3 wrong key
      cyc(1, CTL, 32'hAAAAAA01, 0, 8'h00, "R3");
      cyc(0, 8'h00, '0, 1, CTL, "R3");
      // R2 correct key enables; R4 key field reads zero
      cyc(1, CTL, {KEY, 8'h01}, 0, 8'h00, "R2");
      cyc(0, 8'h00, '0, 1, CTL, "R2");
      cyc(0, 8'h00, '0, 1, CTL, "R4");
      // R5 blocked, R7 latch, R8 clear
      cyc(1, 8'h20, 32'h1, 0, 8'h00, "R5");
      cyc(0, 8'h00, '0, 1, STS, "R7");
      cyc(0, 8'h00, '0, 1, STS, "R8");
      // R7 later violation replaces source
      cyc(1, 8'h04, 32'h0, 0, 8'h00, "R5");
      cyc(1, 8'h40, 32'h0, 0, 8'h00, "R5");
      cyc(0, 8'h00, '0, 1, STS, "R7");
      // R9 coincident violation and read
      cyc(1, 8'h30, 32'h0, 0, 8'h00, "R5");
      cyc(1, 8'h38, 32'h0, 1, STS, "R9");
      cyc(0, 8'h00, '0, 1, STS, "R9");
      // R6 unprotected offset allowed while on
      cyc(1, 8'h0C, 32'h5, 0, 8'h00, "R6");
      cyc(0, 8'h00, '0, 1, STS, "R6");
      // R10 control write while on, wrong key, no effect
      cyc(1, CTL, 32'h00000000, 0, 8'h00, "R10");
      cyc(0, 8'h00, '0, 1, CTL, "R3");
      // R12 other read offsets
      cyc(0, 8'h00, '0, 1, 8'h10, "R12");
      // disable with key, then protected write passes
      cyc(1, CTL, {KEY, 8'h00}, 0, 8'h00, "R2");
      cyc(1, 8'h34, 32'h0, 0, 8'h00, "R5");
      cyc(0, 8'h00, '0, 1, STS, "R5");
      idle();

      for (int i = 0; i < 3000; i++) begin
         r  = $urandom % 16;
         we = ($urandom % 4) != 0;
         if (r < 8) wo = 8'h04 + 8'(r == 1 ? 8'h1C : r == 2 ? 8'h2C : r == 3 ? 8'h30 :
                                     r == 4 ? 8'h34 : r == 5 ? 8'h3C : 8'h00);
         else if (r < 11) wo = CTL;
         else wo = 8'($urandom);
         wd = $urandom;
         if (wo == CTL && ($urandom % 2) == 0) wd[31:8] = KEY;
         re = ($urandom % 3) == 0;
         ro = (($urandom % 4) == 0) ? CTL : (($urandom % 4) == 0) ? 8'($urandom) : STS;
         cyc(we, wo, wd, re, ro, "");
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule